// File: doc/BRIEF.md
# Fractional PLL Multiplier Calculator

This block takes a wanted PLL output frequency and the frequency of the PLL's reference clock, both in hertz. It works out the settings for a PLL whose multiplier has two parts: an integer field and a 22-bit binary fraction. The PLL output is the reference times (integer field + 1 + fraction / 2^22). The block also reports the frequency that those settings will really produce, because the fraction is quantised. A request that no legal setting can serve raises an error pulse instead.

A request starts with a single-cycle strobe. The mode input picks one of two ways to treat a wanted rate that lies outside the legal output band. In commit mode the request is rejected. In query mode the request is moved to the nearest edge of the band and then solved. Both divisions go through one shared restoring divider that produces one quotient bit per cycle, so a request takes a little over a hundred cycles. Each request ends in exactly one valid pulse or one error pulse.

Top module: `fpll_mult_calc`

## Requirements
- R1: On a valid result, `nd_o` equals floor(effective rate / reference) - 1.
- R2: On a valid result, `frac_o` equals (remainder * 2^22 + floor(reference / 2)) / reference, truncated. This is round-to-nearest, with a half rounding up.
- R3: On a valid result, `rate_o` equals reference * (`nd_o` + 1) + floor((reference * `frac_o` + 2^21) / 2^22).
- R4: With `query_i` = 0, a wanted rate below 620,000,000 or above 700,000,000 (zero included) ends in an error. Both band edges are accepted.
- R5: With `query_i` = 1, a wanted rate outside the band is replaced by the nearer band edge and then solved. This means a zero request solves as 620,000,000.
- R6: An integer quotient of 0, or a quotient of 2^ND_W - 1 (63) or more, ends in an error. Any valid `nd_o` is therefore at most 61.
- R7: A rounded fraction above 2^22 - 1 ends in an error.
- R8: A reference rate of zero ends in an error.
- R9: Every accepted strobe yields exactly one single-cycle pulse on either `valid_o` or `err_o`, never both. `busy_o` is high from the cycle after acceptance until the result cycle, and low in the result cycle.
- R10: A strobe that arrives while `busy_o` is high is ignored. The running result is unchanged and no extra result follows.
- R11: After reset, `busy_o`, `valid_o`, `err_o`, `nd_o`, `frac_o` and `rate_o` are all zero. The result fields are cleared on an error and otherwise hold until the next valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Single-cycle request strobe |
| query_i | input | 1 | 1 = clamp an out-of-band rate, 0 = reject it |
| req_rate_i | input | 32 | Wanted output rate in Hz |
| ref_rate_i | input | 32 | Reference rate in Hz |
| busy_o | output | 1 | A request is being solved |
| valid_o | output | 1 | Result fields updated this cycle |
| err_o | output | 1 | Request could not be met |
| nd_o | output | 6 | Integer multiplier field (multiplier minus one) |
| frac_o | output | 22 | Fraction field in units of 2^-22 |
| rate_o | output | 33 | Output rate the settings produce, in Hz |

## Verification
The bench probes the exact band edges in commit mode. A comparison that is off by one would either reject 620 MHz or 700 MHz, or accept one hertz beyond them. A remainder that sits exactly halfway between two fraction codes checks the rounding: a divider without the half-divisor bias returns a fraction one code low, and the achieved rate is then off by four hertz. A remainder one below the reference checks fraction overflow: a design without that check would emit a wrapped fraction of zero as a valid result. The bench also tests integer quotients of 62 and 63 against the field limit, a zero quotient, a zero reference, and clamping from both sides in query mode. Finally, a second strobe is sent mid-computation to show that it neither changes the result nor produces a second pulse.

// File: rtl/fpll_calc_pkg.sv
// Shared types for the fractional PLL multiplier calculator.
package fpll_calc_pkg;
    // Sequencer states of the calculator.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FAIL  = 3'd1,
        ST_DIV1  = 3'd2,
        ST_DIV2  = 3'd3,
        ST_FINAL = 3'd4
    } calc_state_t;
endpackage

// File: rtl/fpll_band_gate.sv
// Band gate: decides how a wanted rate relates to the legal output band.
// In query mode it moves an out-of-band rate to the nearer edge; in commit
// mode it passes the rate unchanged and flags it for rejection.
// Assumes LO_HZ <= HI_HZ. Purely combinational.
module fpll_band_gate #(
    parameter int          RATE_W = 32,
    parameter int unsigned LO_HZ  = 620_000_000,
    parameter int unsigned HI_HZ  = 700_000_000
) (
    input  logic [RATE_W-1:0] rate_i,
    input  logic              query_i,
    output logic [RATE_W-1:0] eff_o,
    output logic              reject_o
);
    localparam logic [RATE_W-1:0] LO_L = RATE_W'(LO_HZ);
    localparam logic [RATE_W-1:0] HI_L = RATE_W'(HI_HZ);

    logic below, above;

    // Compare against both band edges and pick the effective rate.
    always_comb begin
        below    = rate_i < LO_L;
        above    = rate_i > HI_L;
        reject_o = !query_i && (below || above);
        if (query_i && below)      eff_o = LO_L;
        else if (query_i && above) eff_o = HI_L;
        else                       eff_o = rate_i;
    end
endmodule

// File: rtl/fpll_seq_div.sv
// Restoring divider, one quotient bit per cycle. A start pulse loads the
// operands; DVD_W cycles later done pulses for one cycle with quotient and
// remainder. Assumes a nonzero divisor and no start while a division runs.
module fpll_seq_div #(
    parameter int DVD_W = 54,
    parameter int DVS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             done_o,
    output logic [DVD_W-1:0] quo_o,
    output logic [DVS_W-1:0] rem_o
);
    localparam int            CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

    logic [DVS_W-1:0] rem_q;
    logic [DVD_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DVS_W:0]   trial;
    logic             fits;

    // Shift the next dividend bit into the partial remainder and trial-subtract.
    always_comb begin
        trial = {rem_q, quo_q[DVD_W-1]};
        fits  = trial >= {1'b0, divisor_i};
    end

    // Iterate one bit per cycle and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                rem_q <= '0;
                quo_q <= dividend_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= DVS_W'(fits ? trial - {1'b0, divisor_i} : trial);
                quo_q <= {quo_q[DVD_W-2:0], fits};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    run_q  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;
endmodule

// File: rtl/fpll_rate_eval.sv
// Achieved-rate evaluator: ref*(nd+1) plus ref*frac/2^FRAC_W rounded to
// nearest by adding half an LSB before the shift. Purely combinational.
// Assumes the result fits in RATE_W+1 bits.
module fpll_rate_eval #(
    parameter int RATE_W = 32,
    parameter int FRAC_W = 22,
    parameter int ND_W   = 6
) (
    input  logic [RATE_W-1:0] ref_i,
    input  logic [ND_W-1:0]   nd_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [RATE_W:0]   rate_o
);
    localparam int PW = RATE_W + FRAC_W + 1;
    localparam int BW = RATE_W + ND_W + 1;
    localparam logic [PW-1:0] HALF = PW'(1) << (FRAC_W - 1);

    logic [PW-1:0]     prod;
    logic [BW-1:0]     base;
    logic [RATE_W:0]   part;

    // Integer part plus rounded fractional contribution.
    always_comb begin
        prod   = PW'(ref_i) * PW'(frac_i) + HALF;
        part   = (RATE_W+1)'(prod >> FRAC_W);
        base   = BW'(ref_i) * (BW'(nd_i) + BW'(1));
        rate_o = (RATE_W+1)'(base) + part;
    end
endmodule

// File: rtl/fpll_mult_calc.sv
// Fractional PLL multiplier calculator (top). From a wanted rate and a
// reference rate it derives the integer field, the rounded FRAC_W-bit
// fraction and the achieved rate, or an error. One shared sequential
// divider runs twice per request. Assumes start_i is a single-cycle pulse;
// pulses seen while busy are dropped.
module fpll_mult_calc #(
    parameter int          RATE_W = 32,
    parameter int          FRAC_W = 22,
    parameter int          ND_W   = 6,
    parameter int unsigned LO_HZ  = 620_000_000,
    parameter int unsigned HI_HZ  = 700_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              query_i,
    input  logic [RATE_W-1:0] req_rate_i,
    input  logic [RATE_W-1:0] ref_rate_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic              err_o,
    output logic [ND_W-1:0]   nd_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [RATE_W:0]   rate_o
);
    import fpll_calc_pkg::*;

    localparam int               DIV_W     = RATE_W + FRAC_W;
    localparam logic [DIV_W-1:0] ND_LIMIT  = DIV_W'((1 << ND_W) - 1);
    localparam logic [DIV_W-1:0] FRAC_MASK = DIV_W'((64'd1 << FRAC_W) - 1);

    calc_state_t       state_q;
    logic [RATE_W-1:0] eff_rate, req_q, ref_q, rem1_q;
    logic              reject;
    logic [ND_W-1:0]   nd_q;
    logic [FRAC_W-1:0] frac_q;
    logic [RATE_W:0]   ach_rate;
    logic              div_go_q, div_done;
    logic [DIV_W-1:0]  div_dvd, div_quo;
    logic [RATE_W-1:0] div_rem;

    fpll_band_gate #(.RATE_W(RATE_W), .LO_HZ(LO_HZ), .HI_HZ(HI_HZ)) u_gate (
        .rate_i   (req_rate_i),
        .query_i  (query_i),
        .eff_o    (eff_rate),
        .reject_o (reject)
    );

    // Dividend: the rate itself first, then remainder*2^FRAC_W plus half the reference.
    always_comb begin
        if (state_q == ST_DIV2)
            div_dvd = {rem1_q, {FRAC_W{1'b0}}} + DIV_W'(ref_q >> 1);
        else
            div_dvd = DIV_W'(req_q);
    end

    fpll_seq_div #(.DVD_W(DIV_W), .DVS_W(RATE_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_go_q),
        .dividend_i (div_dvd),
        .divisor_i  (ref_q),
        .done_o     (div_done),
        .quo_o      (div_quo),
        .rem_o      (div_rem)
    );

    fpll_rate_eval #(.RATE_W(RATE_W), .FRAC_W(FRAC_W), .ND_W(ND_W)) u_eval (
        .ref_i  (ref_q),
        .nd_i   (nd_q),
        .frac_i (frac_q),
        .rate_o (ach_rate)
    );

    assign busy_o = (state_q != ST_IDLE);

    // Request sequencer: accept, divide twice, check limits, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            ref_q    <= '0;
            rem1_q   <= '0;
            nd_q     <= '0;
            frac_q   <= '0;
            div_go_q <= 1'b0;
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
            nd_o     <= '0;
            frac_o   <= '0;
            rate_o   <= '0;
        end else begin
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
            div_go_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        req_q <= eff_rate;
                        ref_q <= ref_rate_i;
                        if (reject || ref_rate_i == '0) begin
                            state_q <= ST_FAIL;
                        end else begin
                            state_q  <= ST_DIV1;
                            div_go_q <= 1'b1;
                        end
                    end
                end
                ST_DIV1: begin
                    if (div_done) begin
                        if (div_quo == '0 || div_quo >= ND_LIMIT) begin
                            state_q <= ST_FAIL;
                        end else begin
                            nd_q     <= ND_W'(div_quo - DIV_W'(1));
                            rem1_q   <= div_rem;
                            div_go_q <= 1'b1;
                            state_q  <= ST_DIV2;
                        end
                    end
                end
                ST_DIV2: begin
                    if (div_done) begin
                        if (div_quo > FRAC_MASK) begin
                            state_q <= ST_FAIL;
                        end else begin
                            frac_q  <= FRAC_W'(div_quo);
                            state_q <= ST_FINAL;
                        end
                    end
                end
                ST_FINAL: begin
                    valid_o <= 1'b1;
                    nd_o    <= nd_q;
                    frac_o  <= frac_q;
                    rate_o  <= ach_rate;
                    state_q <= ST_IDLE;
                end
                default: begin
                    err_o   <= 1'b1;
                    nd_o    <= '0;
                    frac_o  <= '0;
                    rate_o  <= '0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/fpll_mult_calc_chk.sv
// Protocol checker for fpll_mult_calc, attached by bind below.
module fpll_mult_calc_chk #(
    parameter int ND_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            valid_o,
    input logic            err_o,
    input logic [ND_W-1:0] nd_o
);
    localparam logic [ND_W-1:0] ND_TOP = ND_W'((1 << ND_W) - 3);

    // R9: never both outcomes at once
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));
    // R9: outcome lasts a single cycle
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || err_o) |=> !(valid_o || err_o));
    // R9: an outcome closes a busy period
    p_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || err_o) |-> ($past(busy_o) && !busy_o));
    // R10: work begins only from a strobe
    p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    // R6: a published integer field stays below the limit
    p_nd_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (nd_o <= ND_TOP));
endmodule

bind fpll_mult_calc fpll_mult_calc_chk #(.ND_W(ND_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .err_o   (err_o),
    .nd_o    (nd_o)
);

// File: tb/test_fpll_mult_calc.sv
`timescale 1ns/1ps
module test_fpll_mult_calc;
    localparam longint unsigned LO = 620_000_000;
    localparam longint unsigned HI = 700_000_000;
    localparam int WD_CYCLES = 100_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        query_i = 1'b0;
    logic [31:0] req_rate_i = '0;
    logic [31:0] ref_rate_i = '0;
    logic        busy_o, valid_o, err_o;
    logic [5:0]  nd_o;
    logic [21:0] frac_o;
    logic [32:0] rate_o;

    int vectors = 0;
    int fails = 0;

    fpll_mult_calc i_fpll_mult_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .query_i(query_i),
        .req_rate_i(req_rate_i), .ref_rate_i(ref_rate_i), .busy_o(busy_o),
        .valid_o(valid_o), .err_o(err_o), .nd_o(nd_o), .frac_o(frac_o),
        .rate_o(rate_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected outcome from the requirement formulas.
    task automatic model(input longint unsigned req, input longint unsigned rf, input bit q,
                         output bit e, output longint unsigned nd, output longint unsigned fr,
                         output longint unsigned ach);
        longint unsigned eff, quo, rem;
        e = 0; nd = 0; fr = 0; ach = 0;
        eff = req;
        if (q && req < LO) eff = LO;
        if (q && req > HI) eff = HI;
        if ((!q && (req < LO || req > HI)) || rf == 0) begin e = 1; return; end
        quo = eff / rf;
        rem = eff % rf;
        if (quo == 0 || quo >= 63) begin e = 1; return; end
        nd = quo - 1;
        fr = (rem * (64'd1 << 22) + rf / 2) / rf;
        if (fr > 64'h3F_FFFF) begin e = 1; nd = 0; fr = 0; return; end
        ach = rf * quo + ((rf * fr + (64'd1 << 21)) >> 22);
    endtask

    task automatic wait_result(output int n);
        n = 0;
        while (!(valid_o || err_o) && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    // One request, full check of outcome and fields.
    task automatic run(input longint unsigned req, input longint unsigned rf, input bit q,
                       input string tag);
        bit e;
        longint unsigned nd, fr, ach;
        int n;
        model(req, rf, q, e, nd, fr, ach);
        @(negedge clk);
        req_rate_i = req[31:0]; ref_rate_i = rf[31:0]; query_i = q; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, {tag, " R9 busy after start"}, busy_o, 1);
        wait_result(n);
        check(n < 400, {tag, " R9 result arrives"}, n, 0);
        check(err_o == e && valid_o == !e, {tag, " outcome (err)"}, err_o, e);
        check(nd_o == nd, {tag, " R1 nd field"}, nd_o, nd);
        check(frac_o == fr, {tag, " R2 fraction"}, frac_o, fr);
        check(rate_o == ach, {tag, " R3 achieved rate"}, rate_o, ach);
        @(negedge clk);
        check(!(valid_o || err_o), {tag, " R9 one-cycle pulse"}, valid_o | err_o, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!busy_o && !valid_o && !err_o, "R11 reset flags", {busy_o, valid_o, err_o}, 0);
        check(nd_o == 0 && frac_o == 0 && rate_o == 0, "R11 reset fields", rate_o, 0);
    endtask

    task automatic t_exact();
        run(660_000_000, 12_000_000, 1'b0, "R1 exact multiple");
        run(688_128_000, 24_576_000, 1'b0, "R1 exact 28x");
    endtask

    task automatic t_fraction();
        run(650_000_000, 12_000_000, 1'b0, "R2 sixth fraction");
        run(620_756_994, 16_777_216, 1'b0, "R2 half rounds up R3 rate");
    endtask

    task automatic t_commit_band();
        run(619_999_999, 12_000_000, 1'b0, "R4 below band");
        run(700_000_001, 12_000_000, 1'b0, "R4 above band");
        run(620_000_000, 12_000_000, 1'b0, "R4 low edge");
        run(700_000_000, 12_000_000, 1'b0, "R4 high edge");
        run(0, 12_000_000, 1'b0, "R4 zero request");
        // R11: fields cleared by the error just seen, held otherwise
        check(nd_o == 0 && rate_o == 0, "R11 cleared after error", rate_o, 0);
    endtask

    task automatic t_query_clamp();
        run(800_000_000, 12_000_000, 1'b1, "R5 clamp high");
        run(100, 12_000_000, 1'b1, "R5 clamp low");
        run(0, 12_000_000, 1'b1, "R5 zero clamps");
        run(650_000_000, 12_000_000, 1'b1, "R5 in band query");
    endtask

    task automatic t_nd_limits();
        run(651_000_000, 10_500_000, 1'b0, "R6 quotient 62");
        run(661_500_000, 10_500_000, 1'b0, "R6 quotient 63");
        run(650_000_000, 800_000_000, 1'b0, "R6 quotient 0");
    endtask

    task automatic t_frac_overflow();
        run(659_999_999, 12_000_000, 1'b0, "R7 fraction overflow");
    endtask

    task automatic t_zero_ref();
        run(650_000_000, 0, 1'b0, "R8 zero reference");
    endtask

    // A strobe during a computation must not disturb it.
    task automatic t_ignore_start();
        bit e;
        longint unsigned nd, fr, ach;
        int n;
        int extra;
        model(650_000_000, 12_000_000, 1'b0, e, nd, fr, ach);
        @(negedge clk);
        req_rate_i = 650_000_000; ref_rate_i = 12_000_000; query_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        req_rate_i = 688_128_000; ref_rate_i = 24_576_000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_result(n);
        check(valid_o == 1'b1, "R10 first request completes", valid_o, 1);
        check(nd_o == nd && frac_o == fr, "R10 result of first request", nd_o, nd);
        check(rate_o == ach, "R10 rate of first request", rate_o, ach);
        extra = 0;
        repeat (200) begin
            @(negedge clk);
            if (valid_o || err_o) extra++;
        end
        check(extra == 0 && !busy_o, "R10 no second result", extra, 0);
    endtask

    initial begin
        #(WD_CYCLES * 10);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", WD_CYCLES, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_exact();
        t_fraction();
        t_commit_band();
        t_query_clamp();
        t_nd_limits();
        t_frac_overflow();
        t_zero_ref();
        t_ignore_start();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule